// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block holds the floating-point registers of a processor core. Beside each 64-bit register it keeps a 3-bit tag that records how the register was last interpreted: as raw bits with no format yet (uninterpreted), or as a single, double, word or long value, or as unknown once it has been used inconsistently. Any read whose requested format conflicts with the stored tag is answered with a fixed quiet NaN for that format, so software that mixes formats sees a predictable value.

A static mode input picks the register width. In wide mode every register holds a full 64-bit value. In narrow mode each register holds 32 bits, and a 64-bit value uses an even/odd pair: the low word sits in the even register and the high word in the odd register above it. Addressing a 64-bit value at an odd index is reported as a reserved-instruction exception. There is one synchronous write port and one combinational read port. The read port's strobe commits the tag changes that the read implies. A write with a format that cannot be stored raises a format fault.

Top module: `fpr_tagfile`

## Requirements
- R1: After reset every register reads as zero and every tag is uninterpreted, so a first read in any data format returns 0 and raises no exception.
- R2: In narrow mode a double or long write at an even index n stores the low 32 bits in register n and the high 32 bits in register n+1, and a read of the same format at n returns the full 64-bit value.
- R3: In narrow mode a write or read at an odd index whose format is 64-bit (uninterpreted, double, long, 64-bit uninterpreted) pulses the reserved-instruction exception. Such a write sets the tags of the register and the one above it to unknown. Such a read returns 0.
- R4: Formats are encoded on 3 bits: 0 uninterpreted, 1 single, 2 double, 3 word, 4 long, 5 unknown, 6 uninterpreted 32-bit, 7 uninterpreted 64-bit. A read that requests 0 or 5 is served in the register's current tag.
- R5: A strobed read of a register whose tag is uninterpreted sets the tag to the effective requested format.
- R6: When the effective requested format differs from the tag, the tag becomes unknown on the strobe. Whenever the tag is or becomes unknown, the read returns the quiet NaN of the requested format: 0x7FBFFFFF for single, 0x7FFFFFFF for word, 0x7FF7FFFFFFFFFFFF for double and 0x7FFFFFFFFFFFFFFF for long.
- R7: Single and word reads return only the low 32 bits of the register, with bits 63:32 zero, in both modes.
- R8: In wide mode a single, word or 32-bit uninterpreted write stores the value in bits 31:0 and 0xDEADC0DE in bits 63:32.
- R9: Formats 6 and 7 write 32 or 64 bits and tag the register uninterpreted. In narrow mode all 32-bit writes store the value zero-extended.
- R10: A write with format 5 sets that register's tag to unknown and pulses the format fault. A strobed read whose effective format is not one the read can serve pulses the format fault and returns 0.
- R11: Exception outputs are one-cycle pulses in the cycle after the clock edge of the access that caused them. A read without its strobe changes no tag.
- R12: When a strobed read and a write address the same register in one cycle, the write's tag update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1: 64-bit registers, 0: 32-bit registers paired for 64-bit values |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IW | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe, commits tag updates of the read |
| rd_idx | input | IW | Read register index |
| rd_fmt | input | 3 | Requested read format code |
| rd_data | output | 64 | Combinational read data |
| rsvd_exc | output | 1 | Reserved-instruction exception pulse |
| fmt_fault | output | 1 | Unrecognised-format fault pulse |

## Verification
On every cycle the assertions check that no exception pulse appears without a strobed access on the previous edge, that narrow-format reads never drive the upper 32 bits, and that both pulses are low just after reset. The tag history is internal, so the exact NaN substitution, the adoption of a format by an uninterpreted tag, the even/odd pairing and the write-wins collision can only be shown by the bench's scenarios. The bench compares against a model of registers and tags built from the requirements, first in directed sequences and then in random traffic over a small set of indices in both modes.

// File: rtl/fpr_tagfile.sv
module fpr_tagfile #(
  parameter int NREGS = 32,
  localparam int IW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode64,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [2:0]    wr_fmt,
  input  logic [63:0]   wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [2:0]    rd_fmt,
  output logic [63:0]   rd_data,
  output logic          rsvd_exc,
  output logic          fmt_fault
);
  // NREGS must be even so that every even index has a partner above it.
  localparam logic [2:0] F_UNI = 3'd0, F_SGL = 3'd1, F_DBL = 3'd2, F_WRD = 3'd3,
                         F_LNG = 3'd4, F_UNK = 3'd5, F_U32 = 3'd6, F_U64 = 3'd7;
  localparam logic [31:0] FILL_HI = 32'hDEADC0DE;

  logic [63:0] regs [NREGS];
  logic [2:0]  tags [NREGS];

  // read side
  logic [2:0]    cur_tag, eff_fmt, adopt_tag, rd_tag;
  logic          rd_rsvd, rd_fault;
  logic [IW-1:0] rd_hi;

  assign cur_tag   = tags[rd_idx];
  assign eff_fmt   = (rd_fmt == F_UNI || rd_fmt == F_UNK) ? cur_tag : rd_fmt;
  assign adopt_tag = (cur_tag == F_UNI) ? eff_fmt : cur_tag;
  assign rd_tag    = (eff_fmt != adopt_tag) ? F_UNK : adopt_tag;
  assign rd_hi     = rd_idx | IW'(1);

  always_comb begin
    rd_data  = '0;
    rd_rsvd  = 1'b0;
    rd_fault = 1'b0;
    if (rd_tag == F_UNK) begin
      case (eff_fmt)
        F_SGL:   rd_data = 64'h0000_0000_7FBF_FFFF;
        F_WRD:   rd_data = 64'h0000_0000_7FFF_FFFF;
        F_DBL:   rd_data = 64'h7FF7_FFFF_FFFF_FFFF;
        F_LNG:   rd_data = 64'h7FFF_FFFF_FFFF_FFFF;
        default: rd_fault = 1'b1;
      endcase
    end else begin
      case (eff_fmt)
        F_SGL, F_WRD: rd_data = {32'h0, regs[rd_idx][31:0]};
        F_UNI, F_DBL, F_LNG: begin
          if (mode64)          rd_data = regs[rd_idx];
          else if (!rd_idx[0]) rd_data = {regs[rd_hi][31:0], regs[rd_idx][31:0]};
          else                 rd_rsvd = 1'b1;
        end
        default: rd_fault = 1'b1;
      endcase
    end
  end

  // write side
  logic          w_narrow, w_bad;
  logic [2:0]    w_tag;
  logic          w_odd_wide;
  logic [IW:0]   wr_next;

  always_comb begin
    w_narrow = 1'b0;
    w_bad    = 1'b0;
    w_tag    = wr_fmt;
    case (wr_fmt)
      F_U32:        begin w_narrow = 1'b1; w_tag = F_UNI; end
      F_SGL, F_WRD: w_narrow = 1'b1;
      F_U64:        w_tag = F_UNI;
      F_UNI, F_DBL, F_LNG: ;
      default:      begin w_bad = 1'b1; w_tag = F_UNK; end
    endcase
  end

  assign w_odd_wide = !w_narrow && !w_bad && !mode64 && wr_idx[0];
  assign wr_next    = {1'b0, wr_idx} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        regs[i] <= '0;
        tags[i] <= F_UNI;
      end
      rsvd_exc  <= 1'b0;
      fmt_fault <= 1'b0;
    end else begin
      rsvd_exc  <= (rd_en && rd_rsvd) || (wr_en && w_odd_wide);
      fmt_fault <= (rd_en && rd_fault) || (wr_en && w_bad);
      if (rd_en)
        tags[rd_idx] <= rd_tag;
      if (wr_en) begin
        if (w_bad) begin
          tags[wr_idx] <= F_UNK;
        end else if (w_narrow) begin
          regs[wr_idx] <= {mode64 ? FILL_HI : 32'h0, wr_data[31:0]};
          tags[wr_idx] <= w_tag;
        end else if (mode64) begin
          regs[wr_idx] <= wr_data;
          tags[wr_idx] <= w_tag;
        end else if (!wr_idx[0]) begin
          regs[wr_idx]         <= {32'h0, wr_data[31:0]};
          regs[wr_idx | IW'(1)] <= {32'h0, wr_data[63:32]};
          tags[wr_idx]         <= w_tag;
          tags[wr_idx | IW'(1)] <= w_tag;
        end else begin
          tags[wr_idx] <= F_UNK;
          if (wr_next < (IW+1)'(NREGS))
            tags[wr_next[IW-1:0]] <= F_UNK;
        end
      end
    end
  end
endmodule

// File: rtl/fpr_tagfile_chk.sv
module fpr_tagfile_chk #(
  parameter int NREGS = 32,
  localparam int IW = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode64,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    rd_fmt,
  input logic [63:0]   rd_data,
  input logic          rsvd_exc,
  input logic          fmt_fault
);
  AST_RSVD_ONLY_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |-> ($past(!mode64) && $past(wr_en || rd_en))) else $error("rsvd"); // R3
  AST_FAULT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_fault |-> $past(wr_en || rd_en)) else $error("fault"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_en && !rd_en) |-> (!rsvd_exc && !fmt_fault)) else $error("idle"); // R11
  AST_NARROW_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fmt == 3'd1 || rd_fmt == 3'd3) |-> rd_data[63:32] == 32'h0) else $error("upper"); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!rsvd_exc && !fmt_fault)) else $error("reset"); // R1
endmodule

bind fpr_tagfile fpr_tagfile_chk #(.NREGS(NREGS)) u_chk (.*);

// File: tb/tb_fpr_tagfile.sv
module tb_fpr_tagfile;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0, mode64 = 1;
  logic wr_en = 0, rd_en = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [2:0] wr_fmt = '0, rd_fmt = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic rsvd_exc, fmt_fault;

  fpr_tagfile #(.NREGS(N)) dut (.*);

  always #5 clk = ~clk;

  int total = 0, fails = 0;
  logic [63:0] mdat [N];
  logic [2:0]  mtag [N];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic mread(input int ri, input logic [2:0] rf, input logic m64,
                       output logic [63:0] d, output logic [2:0] nt,
                       output logic rs, output logic ft);
    logic [2:0] ct, ef, at;
    ct = mtag[ri];
    ef = (rf == 0 || rf == 5) ? ct : rf;
    at = (ct == 0) ? ef : ct;
    nt = (ef != at) ? 3'd5 : at;
    d = 0; rs = 0; ft = 0;
    if (nt == 5) begin
      if (ef == 1) d = 64'h7FBFFFFF;
      else if (ef == 3) d = 64'h7FFFFFFF;
      else if (ef == 2) d = 64'h7FF7FFFFFFFFFFFF;
      else if (ef == 4) d = 64'h7FFFFFFFFFFFFFFF;
      else ft = 1;
    end else if (ef == 1 || ef == 3) d = {32'h0, mdat[ri][31:0]};
    else if (ef == 0 || ef == 2 || ef == 4) begin
      if (m64) d = mdat[ri];
      else if (ri % 2 == 0) d = {mdat[ri+1][31:0], mdat[ri][31:0]};
      else rs = 1;
    end else ft = 1;
  endtask

  task automatic mwrite(input int wi, input logic [2:0] wf, input logic [63:0] wd,
                        input logic m64, output logic rs, output logic ft);
    logic [2:0] t;
    rs = 0; ft = 0;
    t = (wf == 6 || wf == 7) ? 3'd0 : wf;
    if (wf == 5) begin ft = 1; mtag[wi] = 5; end
    else if (wf == 6 || wf == 1 || wf == 3) begin
      mdat[wi] = {m64 ? 32'hDEADC0DE : 32'h0, wd[31:0]}; mtag[wi] = t;
    end else if (m64) begin mdat[wi] = wd; mtag[wi] = t; end
    else if (wi % 2 == 0) begin
      mdat[wi] = {32'h0, wd[31:0]}; mdat[wi+1] = {32'h0, wd[63:32]};
      mtag[wi] = t; mtag[wi+1] = t;
    end else begin
      rs = 1; mtag[wi] = 5;
      if (wi + 1 < N) mtag[wi+1] = 5;
    end
  endtask

  // one clock of traffic; returns the combinational read value
  task automatic op(input string r, input logic m64,
                    input logic we, input int wi, input logic [2:0] wf, input logic [63:0] wd,
                    input logic re, input int ri, input logic [2:0] rf,
                    output logic [63:0] got);
    logic [63:0] ed; logic [2:0] nt; logic rrs, rft, wrs, wft;
    @(negedge clk);
    mode64 = m64; wr_en = we; wr_idx = IW'(wi); wr_fmt = wf; wr_data = wd;
    rd_en = re; rd_idx = IW'(ri); rd_fmt = rf;
    #1;
    mread(ri, rf, m64, ed, nt, rrs, rft);
    got = rd_data;
    chk({r, " rd_data"}, rd_data, ed);
    if (re) mtag[ri] = nt;
    wrs = 0; wft = 0;
    if (we) mwrite(wi, wf, wd, m64, wrs, wft);
    @(posedge clk); #1;
    chk({r, " rsvd_exc"}, 64'(rsvd_exc), 64'((re && rrs) || (we && wrs)));
    chk({r, " fmt_fault"}, 64'(fmt_fault), 64'((re && rft) || (we && wft)));
    wr_en = 0; rd_en = 0;
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [63:0] g;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mdat[i] = 0; mtag[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    chk("R1 rsvd after reset", 64'(rsvd_exc), 0);
    chk("R1 fault after reset", 64'(fmt_fault), 0);
    op("R1 fresh double", 1, 0, 0, 0, 0, 1, 5, 2, g);
    chk("R1 zero", g, 0);
    // R8 R9: 32-bit uninterpreted write in wide mode
    op("R8 wr", 1, 1, 3, 6, 64'h1122334455667788, 0, 0, 0, g);
    op("R8 rd", 1, 0, 0, 0, 0, 1, 3, 0, g);
    chk("R8 fill", g, 64'hDEADC0DE55667788);
    // R6 mismatch and sticky unknown
    op("R6 wr", 1, 1, 4, 1, 64'hAAAABBBBCCCCDDDD, 0, 0, 0, g);
    op("R6 dbl", 1, 0, 0, 0, 0, 1, 4, 2, g);
    chk("R6 qnan double", g, 64'h7FF7FFFFFFFFFFFF);
    op("R6 sgl", 1, 0, 0, 0, 0, 1, 4, 1, g);
    chk("R6 qnan single", g, 64'h7FBFFFFF);
    op("R6 lng", 1, 0, 0, 0, 0, 1, 4, 4, g);
    chk("R6 qnan long", g, 64'h7FFFFFFFFFFFFFFF);
    // R11 read without strobe keeps tag
    op("R11 wr", 1, 1, 6, 2, 64'h3FF0000000000001, 0, 0, 0, g);
    op("R11 nostrobe", 1, 0, 0, 0, 0, 0, 6, 1, g);
    op("R11 after", 1, 0, 0, 0, 0, 1, 6, 2, g);
    chk("R11 tag kept", g, 64'h3FF0000000000001);
    // R5 adoption
    op("R5 word", 1, 0, 0, 0, 0, 1, 7, 3, g);
    op("R5 long", 1, 0, 0, 0, 0, 1, 7, 4, g);
    chk("R5 adopted word", g, 64'h7FFFFFFFFFFFFFFF);
    // R2 pairing in narrow mode
    op("R2 wr", 0, 1, 8, 4, 64'h0123456789ABCDEF, 0, 0, 0, g);
    op("R2 rd", 0, 0, 0, 0, 0, 1, 8, 4, g);
    chk("R2 pair", g, 64'h0123456789ABCDEF);
    op("R2 hi", 1, 0, 0, 0, 0, 1, 9, 0, g);
    chk("R2 high half", g, 64'h0000000001234567);
    // R3 odd index
    op("R3 odd wr", 0, 1, 11, 2, 64'h5, 0, 0, 0, g);
    op("R3 unk11", 0, 0, 0, 0, 0, 1, 11, 1, g);
    chk("R3 tag11 unknown", g, 64'h7FBFFFFF);
    op("R3 unk12", 0, 0, 0, 0, 0, 1, 12, 3, g);
    chk("R3 tag12 unknown", g, 64'h7FFFFFFF);
    op("R3 odd rd", 0, 0, 0, 0, 0, 1, 9, 4, g);
    chk("R3 odd read zero", g, 0);
    // R10 fault
    op("R10 wr", 1, 1, 13, 5, 64'h9, 0, 0, 0, g);
    op("R10 rd", 1, 0, 0, 0, 0, 1, 13, 0, g);
    chk("R10 read zero", g, 0);
    op("R11 idle", 1, 0, 0, 0, 0, 0, 0, 0, g);
    // R12 collision
    op("R12 both", 1, 1, 14, 2, 64'h4000000000000000, 1, 14, 1, g);
    op("R12 rd", 1, 0, 0, 0, 0, 1, 14, 2, g);
    chk("R12 write wins", g, 64'h4000000000000000);
    // R4 requests served in stored tag
    op("R4 wr", 1, 1, 15, 3, 64'h12345678, 0, 0, 0, g);
    op("R4 uni", 1, 0, 0, 0, 0, 1, 15, 0, g);
    chk("R4 uninterp req", g, 64'h12345678);
    op("R4 unk", 1, 0, 0, 0, 0, 1, 15, 5, g);
    chk("R4 unknown req", g, 64'h12345678);
    // R7 R9 narrow read of 64-bit uninterpreted data
    op("R9 wr", 1, 1, 16, 7, 64'hCAFEF00D87654321, 0, 0, 0, g);
    op("R7 rd", 1, 0, 0, 0, 0, 1, 16, 1, g);
    chk("R7 low only", g, 64'h87654321);
    op("R9 narrow32", 0, 1, 17, 6, 64'hFFFFFFFF0000ABCD, 0, 0, 0, g);
    op("R9 rd", 0, 0, 0, 0, 0, 1, 17, 3, g);
    chk("R9 zero ext", g, 64'h0000ABCD);
    // random traffic, mode held per block
    for (int b = 0; b < 8; b++) begin
      logic m;
      m = $urandom_range(0, 1);
      for (int k = 0; k < 60; k++)
        op("R6 R10 random", m, 1'($urandom_range(0, 1)), $urandom_range(18, 25),
           3'($urandom_range(0, 7)), {$urandom, $urandom},
           1'($urandom_range(0, 1)), $urandom_range(18, 25), 3'($urandom_range(0, 7)), g);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule